// File: doc/BRIEF.md
# Kick-Committed Clock Ratio Controller

This block holds one 32-bit frequency control word and turns it into four clock-enable streams: CPU, internal high-speed bus, external bus and peripheral. Each stream is a train of single-cycle pulses derived from one fast reference clock. The pulse rate of each stream is set by a 4-bit divisor code that maps to a non-linear table of ratios. A 6-bit multiplier code is carried alongside the divisors. It is checked for legality and presented as a status output. No clock is actually multiplied.

Software writes the control word at the register's address as often as it likes. Only the staged copy changes. The enables keep their rates until a write arrives with the commit bit (bit 31) set. That write is validated as a whole. If it is legal, it becomes the active setting, every domain counter restarts so that the new ratios begin phase-aligned, and a one-cycle lock-wait request goes out to an external stabilization timer. If it is not legal, it is refused and a sticky flag records the refusal. Accesses narrower than a full word are rejected and also flagged. A second word, four bytes above the control word, reports both flags and clears them on write-one.

Top module: `clk_ratio_ctl`

## Requirements
- R1: An access to either register with any of the four byte strobes low is ignored: a write leaves all state unchanged, and a read returns 0. Such an access sets a sticky access-error flag, which is bit 1 of the status word at offset 4.
- R2: A full write to the control word (offset 0) with bit 31 low updates only the staged copy. The active settings, the multiplier outputs and the enable rates are unchanged.
- R3: A full write with bit 31 high and all codes legal commits the written fields to the active settings. In the cycle after the write edge, lock_req_o is high for exactly one cycle.
- R4: Divisor codes map as follows: 0→2, 1→3, 2→4, 3→6, 4→8, 5→12, 6→16, 8→24, 9→32, 10→36, 11→48, 13→72. Codes 7, 12, 14 and 15 are prohibited. The divisor fields are CPU at bits 23:20, internal bus at 15:12, external bus at 11:8 and peripheral at 3:0.
- R5: The multiplier code sits at bits 29:24. The only legal values are 5, 7, 11, 14, 15, 17 and 23. pll_code_o shows the active code and pll_mult_o shows (code+1)×2.
- R6: A commit write with any prohibited divisor or multiplier code is refused. The active settings stay unchanged, no lock request is issued, and sticky invalid flag bit 0 of the status word is set. Writing 1 to a status bit clears it.
- R7: Reading offset 0 returns the staged word, with bit 31 and reserved bits 30, 19:16 and 7:4 always 0. Reading offset 4 returns {30'b0, access_error, invalid}. Read data appears in the cycle after the read strobe.
- R8: Each enable output is high for one reference cycle out of every N, where N is the active ratio of its domain.
- R9: On a successful commit, all four counters restart together. Each domain's first enable comes N cycles after the commit edge, with the write edge counted as cycle 0.
- R10: After reset, the active and staged words are 0x0F002204. This is multiplier code 15 (×32), CPU /2, both buses /4 and peripheral /8. Both flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_be | input | 4 | Byte strobes; all four required |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| en_cpu | output | 1 | CPU clock enable pulse |
| en_ibus | output | 1 | Internal high-speed bus enable pulse |
| en_xbus | output | 1 | External bus enable pulse |
| en_per | output | 1 | Peripheral enable pulse |
| pll_code_o | output | 6 | Active multiplier code |
| pll_mult_o | output | 8 | Active multiplier value |
| lock_req_o | output | 1 | One-cycle request to start the lock wait |
| inv_flag_o | output | 1 | Sticky refused-commit flag |
| err_flag_o | output | 1 | Sticky narrow-access flag |

## Verification
Commit words are applied that together cover all twelve legal divisor codes and all seven legal multiplier codes. For each one, the first-pulse cycle and the steady period of every domain are measured. This separates a table error from a reload or alignment error. Staged-only writes that set reserved bits are compared with commits of the same fields, which separates the shadow path from the active path. Commits carrying one prohibited divisor, then a prohibited multiplier code, are followed by partial-strobe writes, reads and commits. Together these show that refusal and narrow-access rejection each leave the active rates, the staged readback and the flags in the required state.

// File: rtl/clkr_pkg.sv
package clkr_pkg;

   localparam int unsigned MAX_DIV  = 72;
   localparam int unsigned CNT_W    = $clog2(MAX_DIV);
   localparam int unsigned NUM_DOM  = 4;
   localparam int unsigned KICK_BIT = 31;
   localparam logic [31:0] RW_MASK  = 32'h3FF0_FF0F;

   // ratio for a divisor code; 0 marks a prohibited code
   function automatic logic [7:0] div_ratio(input logic [3:0] code);
      case (code)
         4'd0:    return 8'd2;
         4'd1:    return 8'd3;
         4'd2:    return 8'd4;
         4'd3:    return 8'd6;
         4'd4:    return 8'd8;
         4'd5:    return 8'd12;
         4'd6:    return 8'd16;
         4'd8:    return 8'd24;
         4'd9:    return 8'd32;
         4'd10:   return 8'd36;
         4'd11:   return 8'd48;
         4'd13:   return 8'd72;
         default: return 8'd0;
      endcase
   endfunction

   function automatic logic pll_legal(input logic [5:0] code);
      case (code)
         6'd5, 6'd7, 6'd11, 6'd14, 6'd15, 6'd17, 6'd23: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   // field position of each domain: 0 cpu, 1 internal bus, 2 external bus, 3 peripheral
   function automatic int unsigned dom_lsb(input int unsigned d);
      case (d)
         0:       return 20;
         1:       return 12;
         2:       return 8;
         default: return 0;
      endcase
   endfunction

   function automatic logic [31:0] pack_word(input logic [5:0] pll, input logic [3:0] cpu,
                                             input logic [3:0] ibus, input logic [3:0] xbus,
                                             input logic [3:0] per);
      return {2'b00, pll, cpu, 4'h0, ibus, xbus, 4'h0, per};
   endfunction

endpackage

// File: rtl/clkr_code_check.sv
module clkr_code_check
   import clkr_pkg::*;
(
   input  logic [31:0]                       word_i,
   output logic                              legal_o,
   output logic [NUM_DOM-1:0][CNT_W-1:0]     per_m1_o,
   output logic [7:0]                        mult_o
);

   logic [NUM_DOM-1:0] dom_ok;
   logic [5:0]         pll_code;

   generate
      for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
         logic [7:0] ratio;
         assign ratio       = div_ratio(word_i[dom_lsb(d) +: 4]);
         assign dom_ok[d]   = (ratio != 8'd0);
         assign per_m1_o[d] = CNT_W'(ratio - 8'd1);
      end
   endgenerate

   assign pll_code = word_i[29:24];
   assign mult_o   = ({2'b00, pll_code} + 8'd1) << 1;
   assign legal_o  = (&dom_ok) && pll_legal(pll_code);

endmodule

// File: rtl/clkr_bus_if.sv
module clkr_bus_if #(
   parameter int unsigned       ADDR_W = 8,
   parameter logic [ADDR_W-1:0] BASE   = '0
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_i,
   input  logic              rd_i,
   input  logic [3:0]        be_i,
   output logic              freq_wr_o,
   output logic              freq_rd_o,
   output logic              stat_wr_o,
   output logic              stat_rd_o,
   output logic              acc_err_o
);

   localparam int unsigned       WORD_W    = ADDR_W - 2;
   localparam logic [WORD_W-1:0] FREQ_WORD = BASE[ADDR_W-1:2];
   localparam logic [WORD_W-1:0] STAT_WORD = FREQ_WORD + 1'b1;

   generate
      if (ADDR_W < 3) begin : g_bad_width
         $error("clkr_bus_if: ADDR_W must be at least 3");
      end
      if (BASE[1:0] != 2'b00) begin : g_bad_align
         $error("clkr_bus_if: BASE must be word aligned");
      end
      if (FREQ_WORD == '1) begin : g_bad_top
         $error("clkr_bus_if: status word would wrap past the address space");
      end
   endgenerate

   logic hit_freq, hit_stat, full;

   assign hit_freq  = (addr_i[ADDR_W-1:2] == FREQ_WORD);
   assign hit_stat  = (addr_i[ADDR_W-1:2] == STAT_WORD);
   assign full      = &be_i;

   assign freq_wr_o = wr_i && hit_freq && full;
   assign freq_rd_o = rd_i && hit_freq && full;
   assign stat_wr_o = wr_i && hit_stat && full;
   assign stat_rd_o = rd_i && hit_stat && full;
   assign acc_err_o = (wr_i || rd_i) && (hit_freq || hit_stat) && !full;

endmodule

// File: rtl/clkr_div.sv
module clkr_div
   import clkr_pkg::*;
#(
   parameter logic [CNT_W-1:0] RST_M1 = CNT_W'(1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_m1_i,
   input  logic [CNT_W-1:0] period_m1_i,
   output logic             en_o
);

   generate
      if (RST_M1 == '0) begin : g_bad_rst
         $error("clkr_div: reset ratio must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt_q <= RST_M1;
      else if (load_i)         cnt_q <= load_m1_i;
      else if (cnt_q == '0)    cnt_q <= period_m1_i;
      else                     cnt_q <= cnt_q - 1'b1;
   end

   assign en_o = (cnt_q == '0);

   // R8: every legal ratio is at least 2, so a pulse never lasts two cycles
   a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      en_o |=> !en_o);

   // R9: a restart suppresses the pulse in the cycle after the commit edge
   a_r9_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> !en_o);

endmodule

// File: rtl/clk_ratio_ctl.sv
module clk_ratio_ctl
   import clkr_pkg::*;
#(
   parameter int unsigned       ADDR_W    = 8,
   parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
   parameter logic [5:0]        RST_PLL   = 6'd15,
   parameter logic [3:0]        RST_CPU   = 4'h0,
   parameter logic [3:0]        RST_IBUS  = 4'h2,
   parameter logic [3:0]        RST_XBUS  = 4'h2,
   parameter logic [3:0]        RST_PER   = 4'h4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [3:0]        bus_be,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              en_cpu,
   output logic              en_ibus,
   output logic              en_xbus,
   output logic              en_per,
   output logic [5:0]        pll_code_o,
   output logic [7:0]        pll_mult_o,
   output logic              lock_req_o,
   output logic              inv_flag_o,
   output logic              err_flag_o
);

   localparam logic [31:0] RST_WORD = pack_word(RST_PLL, RST_CPU, RST_IBUS, RST_XBUS, RST_PER);

   generate
      if (!pll_legal(RST_PLL)) begin : g_bad_pll
         $error("clk_ratio_ctl: reset multiplier code is prohibited");
      end
      for (genvar d = 0; d < NUM_DOM; d++) begin : g_rst_chk
         if (div_ratio(RST_WORD[dom_lsb(d) +: 4]) == 8'd0) begin : g_bad_div
            $error("clk_ratio_ctl: reset divisor code is prohibited");
         end
      end
   endgenerate

   // access decode
   logic freq_wr, freq_rd, stat_wr, stat_rd, acc_err;

   clkr_bus_if #(.ADDR_W(ADDR_W), .BASE(BASE_ADDR)) u_bus (
      .addr_i    (bus_addr),
      .wr_i      (bus_wr),
      .rd_i      (bus_rd),
      .be_i      (bus_be),
      .freq_wr_o (freq_wr),
      .freq_rd_o (freq_rd),
      .stat_wr_o (stat_wr),
      .stat_rd_o (stat_rd),
      .acc_err_o (acc_err)
   );

   // legality of the incoming word and lookup of the active word
   logic                          wr_legal, act_legal;
   logic [NUM_DOM-1:0][CNT_W-1:0] wr_m1, act_m1;
   logic [7:0]                    wr_mult, act_mult;
   logic [31:0]                   staged_q, active_q;

   clkr_code_check u_chk_wr (
      .word_i   (bus_wdata),
      .legal_o  (wr_legal),
      .per_m1_o (wr_m1),
      .mult_o   (wr_mult)
   );

   clkr_code_check u_chk_act (
      .word_i   (active_q),
      .legal_o  (act_legal),
      .per_m1_o (act_m1),
      .mult_o   (act_mult)
   );

   logic kick, commit;
   logic inv_q, err_q, lock_q;
   logic [31:0] rdata_q;

   assign kick   = freq_wr && bus_wdata[KICK_BIT];
   assign commit = kick && wr_legal;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         staged_q <= RST_WORD;
         active_q <= RST_WORD;
         inv_q    <= 1'b0;
         err_q    <= 1'b0;
         lock_q   <= 1'b0;
         rdata_q  <= '0;
      end else begin
         if (freq_wr) staged_q <= bus_wdata & RW_MASK;
         if (commit)  active_q <= bus_wdata & RW_MASK;
         lock_q <= commit;

         if (kick && !wr_legal)           inv_q <= 1'b1;
         else if (stat_wr && bus_wdata[0]) inv_q <= 1'b0;

         if (acc_err)                      err_q <= 1'b1;
         else if (stat_wr && bus_wdata[1]) err_q <= 1'b0;

         if (freq_rd)      rdata_q <= staged_q;
         else if (stat_rd) rdata_q <= {30'b0, err_q, inv_q};
         else              rdata_q <= '0;
      end
   end

   // per-domain enable generators
   logic [NUM_DOM-1:0] en_vec;

   generate
      for (genvar d = 0; d < NUM_DOM; d++) begin : g_div
         localparam logic [CNT_W-1:0] RM1 = CNT_W'(div_ratio(RST_WORD[dom_lsb(d) +: 4]) - 8'd1);
         clkr_div #(.RST_M1(RM1)) u_div (
            .clk         (clk),
            .rst_n       (rst_n),
            .load_i      (commit),
            .load_m1_i   (wr_m1[d]),
            .period_m1_i (act_m1[d]),
            .en_o        (en_vec[d])
         );
      end
   endgenerate

   assign en_cpu     = en_vec[0];
   assign en_ibus    = en_vec[1];
   assign en_xbus    = en_vec[2];
   assign en_per     = en_vec[3];
   assign pll_code_o = active_q[29:24];
   assign pll_mult_o = act_mult;
   assign lock_req_o = lock_q;
   assign inv_flag_o = inv_q;
   assign err_flag_o = err_q;
   assign bus_rdata  = rdata_q;

   // R2: a write without the commit bit never moves the active word
   a_r2_staged_only: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !bus_wdata[KICK_BIT]) |=> (active_q == $past(active_q)));

   // R6: a refused commit keeps the active word and raises the invalid flag
   a_r6_refused: assert property (@(posedge clk) disable iff (!rst_n)
      (kick && !wr_legal) |=> ((active_q == $past(active_q)) && inv_flag_o && !lock_req_o));

   // R1: a narrow access leaves the staged word alone and flags the error
   a_r1_narrow: assert property (@(posedge clk) disable iff (!rst_n)
      acc_err |=> ((staged_q == $past(staged_q)) && err_flag_o));

   // R3: a lock request only follows a write carrying the commit bit
   a_r3_lock_src: assert property (@(posedge clk) disable iff (!rst_n)
      lock_req_o |-> $past(bus_wr && bus_wdata[KICK_BIT] && (&bus_be)));

   // R5: the active settings are always a legal combination
   a_r5_active_legal: assert property (@(posedge clk) disable iff (!rst_n)
      act_legal);

   // R7: the commit bit never appears on the read port
   a_r7_kick_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rdata[KICK_BIT]);

endmodule

// File: tb/clk_ratio_ctl_tb_top.sv
module clk_ratio_ctl_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [3:0]  bus_be = 4'hF;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        en_cpu, en_ibus, en_xbus, en_per;
   logic [5:0]  pll_code_o;
   logic [7:0]  pll_mult_o;
   logic        lock_req_o, inv_flag_o, err_flag_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #5 clk = ~clk;

   clk_ratio_ctl dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_addr   (bus_addr),
      .bus_wr     (bus_wr),
      .bus_rd     (bus_rd),
      .bus_be     (bus_be),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .en_cpu     (en_cpu),
      .en_ibus    (en_ibus),
      .en_xbus    (en_xbus),
      .en_per     (en_per),
      .pll_code_o (pll_code_o),
      .pll_mult_o (pll_mult_o),
      .lock_req_o (lock_req_o),
      .inv_flag_o (inv_flag_o),
      .err_flag_o (err_flag_o)
   );

   logic [3:0] env;
   assign env = {en_per, en_xbus, en_ibus, en_cpu};

   localparam logic [7:0] A_FREQ = 8'h00;
   localparam logic [7:0] A_STAT = 8'h04;

   // scoreboard of expected read data
   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic        rd_d = 1'b0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   always @(posedge clk) rd_d <= bus_rd;

   always @(negedge clk) begin
      if (rd_d) begin
         if (exp_q.size() == 0) begin
            chk("scoreboard empty on read", 32'd1, 32'd0);
         end else begin
            chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
         end
      end
   end

   // drivers: entered and left at a falling edge
   task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
      bus_addr  = a;
      bus_wdata = d;
      bus_be    = be;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
      bus_be    = 4'hF;
   endtask

   task automatic rd(input logic [7:0] a, input logic [3:0] be, input logic [31:0] exp,
                     input string tag);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      bus_addr = a;
      bus_be   = be;
      bus_rd   = 1'b1;
      @(negedge clk);
      bus_rd   = 1'b0;
      bus_be   = 4'hF;
   endtask

   task automatic period_of(input int d, output int p);
      int guard = 0;
      while (!env[d] && guard < 300) begin @(negedge clk); guard++; end
      p = 0;
      do begin @(negedge clk); p++; end while (!env[d] && p < 300);
   endtask

   task automatic chk_periods(input string tag, input int p0, input int p1, input int p2,
                              input int p3);
      int exp [4];
      int got;
      exp = '{p0, p1, p2, p3};
      for (int d = 0; d < 4; d++) begin
         period_of(d, got);
         chk($sformatf("R8/R4 %s domain %0d period", tag, d), got, exp[d]);
      end
   endtask

   // legal commit: lock pulse, aligned first pulses, multiplier, steady periods
   task automatic kick_ok(input logic [31:0] w, input int p0, input int p1, input int p2,
                          input int p3, input int mult, input string tag);
      int exp [4];
      int first [4];
      exp   = '{p0, p1, p2, p3};
      first = '{0, 0, 0, 0};
      wr(A_FREQ, w, 4'hF);
      chk({"R3 lock pulse ", tag}, lock_req_o, 1);
      for (int k = 1; k <= 80; k++) begin
         for (int d = 0; d < 4; d++) if (first[d] == 0 && env[d]) first[d] = k;
         if (k == 2) chk({"R3 lock single cycle ", tag}, lock_req_o, 0);
         @(negedge clk);
      end
      for (int d = 0; d < 4; d++)
         chk($sformatf("R9 %s domain %0d first pulse", tag, d), first[d], exp[d]);
      chk({"R5 multiplier ", tag}, pll_mult_o, mult);
      chk({"R5 code ", tag}, pll_code_o, w[29:24]);
      chk_periods(tag, p0, p1, p2, p3);
   endtask

   // refused commit: nothing active moves
   task automatic kick_bad(input logic [31:0] w, input int p0, input int p1, input int p2,
                           input int p3, input int mult, input string tag);
      wr(A_FREQ, w, 4'hF);
      chk({"R6 no lock on refusal ", tag}, lock_req_o, 0);
      chk({"R6 invalid flag set ", tag}, inv_flag_o, 1);
      chk({"R6 multiplier kept ", tag}, pll_mult_o, mult);
      chk_periods({"R6 ", tag}, p0, p1, p2, p3);
      rd(A_STAT, 4'hF, 32'h1, {"R6 status invalid bit ", tag});
      rd(A_FREQ, 4'hF, w & 32'h3FF0_FF0F, {"R6 staged follows refused write ", tag});
      wr(A_STAT, 32'h1, 4'hF);
      chk({"R6 write-one clears ", tag}, inv_flag_o, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10: reset state
      chk("R10 multiplier after reset", pll_mult_o, 32);
      chk("R10 flags after reset", {inv_flag_o, err_flag_o}, 0);
      chk("R10 no lock after reset", lock_req_o, 0);
      rd(A_FREQ, 4'hF, 32'h0F00_2204, "R10 control word after reset");
      rd(A_STAT, 4'hF, 32'h0, "R10 status after reset");
      chk_periods("R10 reset", 2, 4, 4, 8);

      // R2 / R7: staged write with reserved bits set, no commit
      wr(A_FREQ, 32'h57DF_B8F6, 4'hF);
      chk("R2 no lock without commit", lock_req_o, 0);
      rd(A_FREQ, 4'hF, 32'h17D0_B806, "R7 reserved bits read zero");
      chk("R2 multiplier unchanged", pll_mult_o, 32);
      chk_periods("R2 staged only", 2, 4, 4, 8);

      // R3 / R4 / R9: commits covering every legal code
      kick_ok(32'h97D0_B806, 72, 48, 24, 16, 48, "x48 /72/48/24/16");
      rd(A_FREQ, 4'hF, 32'h17D0_B806, "R7 commit bit reads zero");
      kick_ok(32'h8510_3509, 3, 6, 12, 32, 12, "x12 /3/6/12/32");
      kick_ok(32'h87A0_0402, 36, 2, 8, 4, 16, "x16 /36/2/8/4");
      kick_ok(32'h8E50_6402, 12, 16, 8, 4, 30, "x30 /12/16/8/4");
      kick_ok(32'h9100_0000, 2, 2, 2, 2, 36, "x36 all /2");
      kick_ok(32'h8BA0_0402, 36, 2, 8, 4, 24, "x24 /36/2/8/4");

      // R6: prohibited divisor codes and multiplier codes
      kick_bad(32'h8F70_2204, 36, 2, 8, 4, 24, "cpu code 7");
      kick_bad(32'h8F00_220E, 36, 2, 8, 4, 24, "peripheral code 14");
      kick_bad(32'h8F00_C204, 36, 2, 8, 4, 24, "ibus code 12");
      kick_bad(32'h9000_2204, 36, 2, 8, 4, 24, "multiplier code 16");

      // R1: narrow accesses
      wr(A_FREQ, 32'h0F00_2204, 4'b0111);
      chk("R1 error flag after narrow write", err_flag_o, 1);
      rd(A_FREQ, 4'hF, 32'h1000_2204, "R1 staged unchanged by narrow write");
      wr(A_FREQ, 32'h8F00_2204, 4'b1110);
      chk("R1 narrow commit gives no lock", lock_req_o, 0);
      chk("R1 narrow commit keeps multiplier", pll_mult_o, 24);
      chk_periods("R1 narrow commit", 36, 2, 8, 4);
      rd(A_FREQ, 4'b1011, 32'h0, "R1 narrow read returns zero");
      rd(A_STAT, 4'hF, 32'h2, "R1 status error bit");
      wr(A_STAT, 32'h2, 4'b0001);
      chk("R1 narrow status write does not clear", err_flag_o, 1);
      wr(A_STAT, 32'h2, 4'hF);
      chk("R1 write-one clears error", err_flag_o, 0);
      rd(A_STAT, 4'hF, 32'h0, "R1 status clear");

      // R3 / R9: return to the reset-like ratios
      kick_ok(32'h8F00_2204, 2, 4, 4, 8, 32, "x32 /2/4/4/8");

      repeat (3) @(negedge clk);
      chk("scoreboard drained", exp_q.size(), 0);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

endmodule